// File: doc/BRIEF.md
# Per-Channel RGB Gamma Lookup

This block applies gamma correction to a stream of 24-bit RGB pixels. Each display channel has its own three 256-entry tables, one for red, one for green and one for blue. Every 8-bit input component selects one 8-bit entry in the table for its colour and channel. All tables sit in a single shared memory.

A host fills the memory through two write strobes. The first sets a write pointer and an auto-increment flag. The second stores one byte at the pointer. A per-channel enable input chooses between the tables and an identity pass-through. Pixels carry a channel number. They are accepted on every cycle without stalling and come out a fixed two cycles later.

The table contents are undefined after reset. Software must load a channel's tables before it enables gamma on that channel.

Top module: `gamma_lut`

## Requirements
- R1: After reset `pix_valid_o` is 0, the write pointer is 0 and auto-increment is off. Two data writes with no address write therefore both land on address 0.
- R2: For channel k, colour c (0 red, 1 green, 2 blue) and index i, the entry sits at address k*768 + c*256 + i. The tables of channel 0 come first, then channel 1, then channel 2.
- R3: An address write loads the pointer from `host_addr_val` and the auto-increment flag from `host_addr_inc`. A data write stores `host_data_val` at the current pointer.
- R4: With auto-increment on, each data write advances the pointer by one.
- R5: With auto-increment off, data writes keep hitting the same address, so the last value written is the one that stays.
- R6: With auto-increment on, a data write at the last address (2303) moves the pointer to 0.
- R7: When an address write and a data write come in the same cycle, the data goes to the old pointer and the pointer then takes the new address.
- R8: When gamma is enabled for a pixel's channel, each output component equals that channel's table entry for its colour, indexed by the input component. Red is carried in bits [23:16], green in [15:8] and blue in [7:0].
- R9: When a channel's bit in `chan_gamma_en` is clear, its pixels come out unchanged, whatever the tables hold.
- R10: A pixel accepted in one cycle appears two cycles later, with `pix_valid_o` high. Back-to-back pixels on different channels are accepted every cycle, with no stall.
- R11: A pixel lookup never waits for a host write. If the lookup reads an entry in the same cycle that the entry is written, it returns the content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_we | input | 1 | Load the write pointer and the auto-increment flag |
| host_addr_inc | input | 1 | Auto-increment flag value |
| host_addr_val | input | 12 | Start address |
| host_data_we | input | 1 | Store one table entry at the pointer |
| host_data_val | input | 8 | Table entry value |
| chan_gamma_en | input | 3 | Per-channel gamma enable; a clear bit selects pass-through |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_chan_i | input | 2 | Channel of the input pixel |
| pix_rgb_i | input | 24 | Input pixel, red in the top byte |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Corrected pixel |

## Verification
The assertions assume two things about the inputs: a valid pixel always names a channel below three, and an address write always gives a start address inside the 2304-entry memory. The stimulus only ever picks channels 0 to 2 and start addresses taken from the layout formula, so neither assumption is violated. The pass-through check also takes `chan_gamma_en` as sampled together with the pixel. The bench therefore changes the enables only between steps, at the falling edge, never in the middle of a pixel's acceptance cycle.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    // colour regions per channel, stored red, green, blue
    localparam int NCOLOUR = 3;
    localparam int COLOUR_RED   = 0;
    localparam int COLOUR_GREEN = 1;
    localparam int COLOUR_BLUE  = 2;
endpackage

// File: rtl/gamma_lut_host_port.sv
module gamma_lut_host_port #(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              addr_inc,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_val,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              inc_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              inc;
    } host_t;

    host_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_we && st_q.inc) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + ADDR_W'(1);
        end
        // an address write in the same cycle overrides the advance
        if (addr_we) begin
            st_d.ptr = addr_val;
            st_d.inc = addr_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = data_we;
    assign mem_waddr = st_q.ptr;
    assign mem_wdata = data_val;
    assign ptr_o     = st_q.ptr;
    assign inc_o     = st_q.inc;
endmodule

// File: rtl/gamma_lut_mem.sv
module gamma_lut_mem #(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int NRD    = 3
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [NRD-1:0][DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // read ports see the content from before a same-edge write
    always_ff @(posedge clk) begin
        for (int p = 0; p < NRD; p++) begin
            rd_q[p] <= mem_q[raddr[p]];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/gamma_lut_pipe.sv
module gamma_lut_pipe
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2,
    parameter int COMP_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                pix_valid_i,
    input  logic [CH_W-1:0]                     pix_chan_i,
    input  logic [NCOLOUR*COMP_W-1:0]           pix_rgb_i,
    input  logic [NUM_CH-1:0]                   gamma_en,
    output logic [NCOLOUR-1:0][ADDR_W-1:0]      raddr,
    input  logic [NCOLOUR-1:0][COMP_W-1:0]      rdata,
    output logic                                pix_valid_o,
    output logic [NCOLOUR*COMP_W-1:0]           pix_rgb_o
);
    localparam int RGB_W   = NCOLOUR * COMP_W;
    localparam int ENTRIES = 1 << COMP_W;
    localparam int CH_SPAN = NCOLOUR * ENTRIES;

    typedef struct packed {
        logic             v1;
        logic [CH_W-1:0]  ch1;
        logic [RGB_W-1:0] rgb1;
        logic             byp1;
        logic             v2;
        logic [RGB_W-1:0] rgb2;
        logic             byp2;
    } pipe_t;

    pipe_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.v1   = pix_valid_i;
        s_d.ch1  = pix_chan_i;
        s_d.rgb1 = pix_rgb_i;
        s_d.byp1 = (int'(pix_chan_i) < NUM_CH) ? ~gamma_en[pix_chan_i] : 1'b1;
        s_d.v2   = s_q.v1;
        s_d.rgb2 = s_q.rgb1;
        s_d.byp2 = s_q.byp1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // table address: channel region, then colour region, then component
    always_comb begin
        for (int c = 0; c < NCOLOUR; c++) begin
            raddr[c] = ADDR_W'(int'(s_q.ch1) * CH_SPAN + c * ENTRIES
                       + int'(s_q.rgb1[(NCOLOUR-1-c)*COMP_W +: COMP_W]));
        end
    end

    assign pix_valid_o = s_q.v2;

    for (genvar g = 0; g < NCOLOUR; g++) begin : g_out
        assign pix_rgb_o[(NCOLOUR-1-g)*COMP_W +: COMP_W] =
            s_q.byp2 ? s_q.rgb2[(NCOLOUR-1-g)*COMP_W +: COMP_W] : rdata[g];
    end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int COMP_W = 8,
    localparam int ENTRIES = 1 << COMP_W,
    localparam int DEPTH   = NUM_CH * NCOLOUR * ENTRIES,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RGB_W   = NCOLOUR * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr_we,
    input  logic              host_addr_inc,
    input  logic [ADDR_W-1:0] host_addr_val,
    input  logic              host_data_we,
    input  logic [COMP_W-1:0] host_data_val,
    input  logic [NUM_CH-1:0] chan_gamma_en,
    input  logic              pix_valid_i,
    input  logic [CH_W-1:0]   pix_chan_i,
    input  logic [RGB_W-1:0]  pix_rgb_i,
    output logic              pix_valid_o,
    output logic [RGB_W-1:0]  pix_rgb_o
);
    logic                               mem_we;
    logic [ADDR_W-1:0]                  mem_waddr;
    logic [COMP_W-1:0]                  mem_wdata;
    logic [ADDR_W-1:0]                  wr_ptr;
    logic                               wr_inc;
    logic [NCOLOUR-1:0][ADDR_W-1:0]     rd_addr;
    logic [NCOLOUR-1:0][COMP_W-1:0]     rd_data;

    gamma_lut_host_port #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(COMP_W)
    ) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_we  (host_addr_we),
        .addr_inc (host_addr_inc),
        .addr_val (host_addr_val),
        .data_we  (host_data_we),
        .data_val (host_data_val),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata),
        .ptr_o    (wr_ptr),
        .inc_o    (wr_inc)
    );

    gamma_lut_mem #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(COMP_W),
        .NRD   (NCOLOUR)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    gamma_lut_pipe #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .COMP_W(COMP_W),
        .ADDR_W(ADDR_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid_i(pix_valid_i),
        .pix_chan_i (pix_chan_i),
        .pix_rgb_i  (pix_rgb_i),
        .gamma_en   (chan_gamma_en),
        .raddr      (rd_addr),
        .rdata      (rd_data),
        .pix_valid_o(pix_valid_o),
        .pix_rgb_o  (pix_rgb_o)
    );
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
    parameter int NUM_CH = 3,
    parameter int COMP_W = 8,
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int CH_W   = 2,
    parameter int RGB_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_addr_we,
    input logic              host_addr_inc,
    input logic [ADDR_W-1:0] host_addr_val,
    input logic              host_data_we,
    input logic [NUM_CH-1:0] chan_gamma_en,
    input logic              pix_valid_i,
    input logic [CH_W-1:0]   pix_chan_i,
    input logic [RGB_W-1:0]  pix_rgb_i,
    input logic              pix_valid_o,
    input logic [RGB_W-1:0]  pix_rgb_o,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              wr_inc
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [1:0]       age_q;
    logic             dv1_q, dv2_q, db1_q, db2_q;
    logic [RGB_W-1:0] drgb1_q, drgb2_q;
    logic             byp_now;
    logic             step_now;

    assign byp_now  = (int'(pix_chan_i) < NUM_CH) ? !chan_gamma_en[pix_chan_i] : 1'b1;
    assign step_now = host_data_we && !host_addr_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q   <= '0;
            dv1_q   <= 1'b0;
            dv2_q   <= 1'b0;
            db1_q   <= 1'b0;
            db2_q   <= 1'b0;
            drgb1_q <= '0;
            drgb2_q <= '0;
        end else begin
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
            dv1_q   <= pix_valid_i;
            dv2_q   <= dv1_q;
            db1_q   <= byp_now;
            db2_q   <= db1_q;
            drgb1_q <= pix_rgb_i;
            drgb2_q <= drgb1_q;
        end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pix_valid_o == dv2_q));

    assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && dv2_q && db2_q) |-> (pix_rgb_o == drgb2_q));

    assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr_we |=> (wr_ptr == $past(host_addr_val) && wr_inc == $past(host_addr_inc)));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now && wr_inc && wr_ptr != LAST) |=> (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now && !wr_inc) |=> $stable(wr_ptr));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now && wr_inc && wr_ptr == LAST) |=> (wr_ptr == '0));

    assert_chan_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |-> (int'(pix_chan_i) < NUM_CH));

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr_we |-> (int'(host_addr_val) < DEPTH));
endmodule

bind gamma_lut gamma_lut_checker #(
    .NUM_CH(NUM_CH),
    .COMP_W(COMP_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .CH_W  (CH_W),
    .RGB_W (RGB_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr_we (host_addr_we),
    .host_addr_inc(host_addr_inc),
    .host_addr_val(host_addr_val),
    .host_data_we (host_data_we),
    .chan_gamma_en(chan_gamma_en),
    .pix_valid_i  (pix_valid_i),
    .pix_chan_i   (pix_chan_i),
    .pix_rgb_i    (pix_rgb_i),
    .pix_valid_o  (pix_valid_o),
    .pix_rgb_o    (pix_rgb_o),
    .wr_ptr       (wr_ptr),
    .wr_inc       (wr_inc)
);

// File: tb/gamma_lut_test.sv
module gamma_lut_test;
    localparam int NUM_CH  = 3;
    localparam int ENTRIES = 256;
    localparam int SPAN    = 3 * ENTRIES;
    localparam int DEPTH   = NUM_CH * SPAN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr_we = 1'b0;
    logic        host_addr_inc = 1'b0;
    logic [11:0] host_addr_val = '0;
    logic        host_data_we = 1'b0;
    logic [7:0]  host_data_val = '0;
    logic [2:0]  chan_gamma_en = '0;
    logic        pix_valid_i = 1'b0;
    logic [1:0]  pix_chan_i = '0;
    logic [23:0] pix_rgb_i = '0;
    logic        pix_valid_o;
    logic [23:0] pix_rgb_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0]  tbl [DEPTH];
    int          m_ptr = 0;
    bit          m_inc = 1'b0;

    logic [23:0] exp_q [$];
    string       tag_q [$];
    int          due_q [$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    gamma_lut uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr_we(host_addr_we), .host_addr_inc(host_addr_inc),
        .host_addr_val(host_addr_val), .host_data_we(host_data_we),
        .host_data_val(host_data_val), .chan_gamma_en(chan_gamma_en),
        .pix_valid_i(pix_valid_i), .pix_chan_i(pix_chan_i), .pix_rgb_i(pix_rgb_i),
        .pix_valid_o(pix_valid_o), .pix_rgb_o(pix_rgb_o)
    );

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [23:0] expect_pix(input int ch, input logic [23:0] rgb);
        logic [23:0] r;
        r = rgb;
        if (chan_gamma_en[ch]) begin
            for (int c = 0; c < 3; c++) begin
                r[(2-c)*8 +: 8] = tbl[ch*SPAN + c*ENTRIES + int'(rgb[(2-c)*8 +: 8])];
            end
        end
        return r;
    endfunction

    // one clock of stimulus; the model is updated in hardware order
    task automatic step(input bit dp, input int ch, input logic [23:0] rgb, input string tag,
                        input bit da, input bit ainc, input int aval,
                        input bit dd, input logic [7:0] dval);
        pix_valid_i   = dp;
        pix_chan_i    = 2'(ch);
        pix_rgb_i     = rgb;
        host_addr_we  = da;
        host_addr_inc = ainc;
        host_addr_val = 12'(aval);
        host_data_we  = dd;
        host_data_val = dval;
        if (dd) begin
            tbl[m_ptr] = dval;
            if (m_inc) m_ptr = (m_ptr == DEPTH-1) ? 0 : m_ptr + 1;
        end
        if (da) begin
            m_ptr = aval;
            m_inc = ainc;
        end
        if (dp) begin
            exp_q.push_back(expect_pix(ch, rgb));
            tag_q.push_back(tag);
            due_q.push_back(cyc + 2);
        end
        @(negedge clk);
        pix_valid_i  = 1'b0;
        host_addr_we = 1'b0;
        host_data_we = 1'b0;
    endtask

    task automatic pix(input int ch, input logic [23:0] rgb, input string tag);
        step(1, ch, rgb, tag, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic set_addr(input int a, input bit inc);
        step(0, 0, 24'h0, "", 1, inc, a, 0, 8'h00);
    endtask

    task automatic put(input logic [7:0] v);
        step(0, 0, 24'h0, "", 0, 0, 0, 1, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 0;
        m_inc = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && pix_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: got unexpected output %h expected none", pix_rgb_o);
            end else begin
                automatic logic [23:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                automatic int d = due_q.pop_front();
                checks++;
                if (pix_rgb_o !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, pix_rgb_o, e);
                end
                checks++;
                if (cyc != d) begin
                    errors++;
                    $display("FAIL R10: output at cycle %0d expected cycle %0d", cyc, d);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: valid low out of reset
        checks++;
        if (pix_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got pix_valid_o %b expected 0", pix_valid_o);
        end

        // R3 R4: load every entry with auto-increment from address 0
        set_addr(0, 1'b1);
        for (int a = 0; a < DEPTH; a++) put(fill_val(a));
        // R6: pointer wrapped, next write lands on address 0
        put(8'hC3);
        chan_gamma_en = 3'b111;
        pix(0, 24'h00_8080, "R6");

        // R8 R2 R10: back-to-back, channel switching every pixel
        pix(0, 24'h12_34_56, "R8");
        pix(1, 24'hFF_00_A0, "R2");
        pix(2, 24'h01_FE_7F, "R8");
        pix(1, 24'h80_80_80, "R10");
        pix(2, 24'hFF_FF_FF, "R2");
        idle(3);

        // R9: channel 1 bypassed, neighbours still corrected
        chan_gamma_en = 3'b101;
        pix(1, 24'hAB_CD_EF, "R9");
        pix(0, 24'hAB_CD_EF, "R8");
        pix(1, 24'h00_10_20, "R9");
        pix(2, 24'hAB_CD_EF, "R8");
        idle(3);
        chan_gamma_en = 3'b111;

        // R5: no auto-increment, repeated writes hit one entry
        set_addr(SPAN + ENTRIES + 8'h40, 1'b0);
        put(8'h11);
        put(8'h22);
        put(8'h33);
        pix(1, 24'h00_40_00, "R5");
        pix(1, 24'h00_41_00, "R5");

        // R7: same-cycle address and data writes
        step(0, 0, 24'h0, "", 1, 1'b1, 2*SPAN + 8'h05, 1, 8'h77);
        put(8'h88);
        pix(1, 24'h00_40_00, "R7");
        pix(2, 24'h05_00_00, "R7");

        // R11: lookup and write of the same entry in the same read cycle
        set_addr(2*SPAN + 2*ENTRIES + 8'h10, 1'b1);
        pix(2, 24'h00_00_10, "R11");
        put(8'h99);
        pix(2, 24'h00_00_10, "R11");
        idle(4);

        // R1: pointer zero and no auto-increment after a second reset
        do_reset();
        checks++;
        if (pix_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got pix_valid_o %b expected 0", pix_valid_o);
        end
        put(8'hA5);
        put(8'h5A);
        pix(0, 24'h00_01_01, "R1");
        pix(0, 24'h01_00_00, "R1");
        idle(5);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: got %0d pending outputs expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule